// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is a synthesizable cycle model of a register-to-register pipelined synchronous static RAM. Each word is 18 bits wide and is split into two 9-bit lanes. The array depth is a parameter. An external master presents an address with a set of chip selects and one of two start strobes. It then steps through a four-beat burst with an advance input, and it writes either whole words or single lanes. Read data leaves through an output register one clock after the access is registered. The tristate pins are split into a data-in bus, a data-out bus and a drive-enable flag.

Two start strobes exist. The processor strobe is gated by the master select and always opens a read. The controller strobe is not gated by the master select and takes its write enables on the same edge. After a burst has started, every clock edge without a strobe either continues the burst at the next address or suspends it at the current address. That cycle is a read or a write, depending on the write inputs. A deselect lets the read already in the pipeline finish before the drive drops. A snooze input parks the block after a fixed count of clock edges. While parked the array keeps its contents and the drive stays off. The block takes new accesses again after a second count of edges once snooze is released.

Top module: `sram_pipe_top`

## Requirements
- R1: When `allWrite_n` is 0 on a write-capable edge, both lanes are written from `dataIn`, whatever `byteWrite_n` and `laneWrite_n` are.
- R2: When `allWrite_n` is 1 and `byteWrite_n` is 0, lane a (bits [8:0]) is written if `laneWrite_n[0]` is 0, and lane b (bits [17:9]) is written if `laneWrite_n[1]` is 0. If neither lane bit is 0, or if `byteWrite_n` is 1, the cycle is a read.
- R3: An edge that starts a cycle with the processor strobe (`procStrobe_n`=0 while `selMain_n`=0) is always a read. The write inputs on that edge have no effect on the array.
- R4: If an access is registered on edge k, its data appears on `dataOut` after edge k+1, with `dataDrive` high. After edge k alone, the drive is still low when coming from an idle state.
- R5: Within a burst, `advance_n`=0 moves to the next beat and `advance_n`=1 repeats the current beat. Only the two low address bits change. With `linearOrder`=1 they count up modulo 4 from the start address. With `linearOrder`=0 the beat number is XORed with the start address.
- R6: `dataDrive` is high only while `outEn_n` is 0 and read data is held. A write cycle forces `dataDrive` low after its edge, whatever `outEn_n` is.
- R7: A controller-strobe edge with `selMain_n`=1, or a strobe edge with `selHi`=0 or `selLo_n`=1, is a deselect. The drive stays on for one more edge and is off after the second edge.
- R8: After `snoozeReq` has been 1 on two consecutive edges, `dataDrive` is 0 and inputs are ignored. Array contents are kept.
- R9: After `snoozeReq` has been 0 on two consecutive edges, the block samples inputs again from the next edge. Write requests on the two recovery edges have no effect.
- R10: A write request on an edge where `snoozeReq` is 1 is dropped. No address of the array changes.
- R11: A processor strobe while `selMain_n` is 1 is blocked. A burst in progress carries on at its own address and ignores `addrIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addrIn | input | ADDR_W | Word address, sampled on start edges |
| selMain_n | input | 1 | Master select, active low; gates the processor strobe |
| selHi | input | 1 | Secondary select, active high |
| selLo_n | input | 1 | Secondary select, active low |
| procStrobe_n | input | 1 | Processor start strobe, active low |
| ctrlStrobe_n | input | 1 | Controller start strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| allWrite_n | input | 1 | Whole-word write, active low |
| byteWrite_n | input | 1 | Enables the per-lane write inputs, active low |
| laneWrite_n | input | 2 | Per-lane writes, active low; bit 0 lane a, bit 1 lane b |
| outEn_n | input | 1 | Output enable, active low, combinational |
| linearOrder | input | 1 | 1 = linear burst order, 0 = interleaved |
| snoozeReq | input | 1 | Power-down request, active high |
| dataIn | input | 18 | Write data |
| dataOut | output | 18 | Registered read data |
| dataDrive | output | 1 | High when the data pins would be driven |

## Verification
If the burst state or the base address is stored wrongly, `dataOut` shows a neighbouring word one edge after the faulty beat. The directed burst runs compare every beat against a model array. If a write is decoded wrongly, the port only shows it once the word is read back. Each write scenario therefore ends in a fresh read two edges later. Faults in the deselect pipeline and the snooze counters show on `dataDrive` at an exact edge. The bench samples one edge early and one edge late, so a counter that is off by one cycle is caught.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // Strobes passed from the control path to the datapath for one edge.
  typedef struct packed {
    logic             rdEn;    // register an array read on this edge
    logic [LANES-1:0] wrLane;  // lanes written on this edge
    logic             flush;   // empty the read pipeline (entering snooze)
  } memCmd_t;
endpackage

// File: rtl/sram_burst.sv
module sram_burst #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [AW-1:0] loadAddr,
  input  logic          linear,
  output logic [AW-1:0] curAddr,
  output logic [AW-1:0] nextAddr
);
  logic [AW-1:0] baseQ;
  logic [1:0]    stepQ;

  function automatic logic [1:0] mixLow(input logic [1:0] b, input logic [1:0] s,
                                        input logic lin);
    return lin ? (b + s) : (b ^ s);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseQ <= '0;
      stepQ <= '0;
    end else if (load) begin
      baseQ <= loadAddr;
      stepQ <= '0;
    end else if (advance) begin
      stepQ <= stepQ + 2'd1;
    end
  end

  assign curAddr  = {baseQ[AW-1:2], mixLow(baseQ[1:0], stepQ, linear)};
  assign nextAddr = {baseQ[AW-1:2], mixLow(baseQ[1:0], stepQ + 2'd1, linear)};

  // R5
  burst_upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (curAddr[AW-1:2] == $past(curAddr[AW-1:2])));
endmodule

// File: rtl/sram_snooze.sv
module sram_snooze #(
  parameter int ENTER_CYC = 2,
  parameter int WAKE_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic snoozeReq,
  output logic sleep,
  output logic enterNow
);
  localparam int MAXC = (ENTER_CYC > WAKE_CYC) ? ENTER_CYC : WAKE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ENTER_LAST = CW'(ENTER_CYC - 1);
  localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYC - 1);

  logic          sleepQ;
  logic [CW-1:0] cntQ;
  logic [CW-1:0] limit;
  logic          flip;

  assign limit    = sleepQ ? WAKE_LAST : ENTER_LAST;
  assign flip     = (snoozeReq != sleepQ) && (cntQ == limit);
  assign enterNow = flip && !sleepQ;
  assign sleep    = sleepQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleepQ <= 1'b0;
      cntQ   <= '0;
    end else if (snoozeReq != sleepQ) begin
      if (flip) begin
        sleepQ <= ~sleepQ;
        cntQ   <= '0;
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end else begin
      cntQ <= '0;
    end
  end

  // R8
  sleep_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> $past(snoozeReq));
  // R9
  sleep_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> !$past(snoozeReq));
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int AW        = 6,
  parameter int ENTER_CYC = 2,
  parameter int WAKE_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addrIn,
  input  logic             selMain_n,
  input  logic             selHi,
  input  logic             selLo_n,
  input  logic             procStrobe_n,
  input  logic             ctrlStrobe_n,
  input  logic             advance_n,
  input  logic             allWrite_n,
  input  logic             byteWrite_n,
  input  logic [LANES-1:0] laneWrite_n,
  input  logic             linearOrder,
  input  logic             snoozeReq,
  output memCmd_t          cmd,
  output logic [AW-1:0]    accAddr,
  output logic             sleep,
  output logic             deselect
);
  logic             activeQ;
  logic             secOk, procStart, ctrlStart;
  logic [LANES-1:0] wrReq, wrKeep;
  logic             load, adv, rdEn;
  logic [LANES-1:0] wrLane;
  logic [AW-1:0]    curAddr, nextAddr;
  logic             enterNow;

  sram_snooze #(.ENTER_CYC(ENTER_CYC), .WAKE_CYC(WAKE_CYC)) uSnooze (
    .clk(clk), .rst_n(rst_n), .snoozeReq(snoozeReq),
    .sleep(sleep), .enterNow(enterNow)
  );

  sram_burst #(.AW(AW)) uBurst (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(adv),
    .loadAddr(addrIn), .linear(linearOrder),
    .curAddr(curAddr), .nextAddr(nextAddr)
  );

  assign secOk     = selHi & ~selLo_n;
  assign procStart = ~procStrobe_n & ~selMain_n;
  assign ctrlStart = ~ctrlStrobe_n & ~procStart;
  assign wrReq     = ~allWrite_n ? '1 : (~byteWrite_n ? ~laneWrite_n : '0);
  assign wrKeep    = wrReq & {LANES{~snoozeReq}};

  always_comb begin
    load     = 1'b0;
    adv      = 1'b0;
    rdEn     = 1'b0;
    wrLane   = '0;
    deselect = 1'b0;
    accAddr  = curAddr;
    if (!sleep) begin
      if (procStart) begin
        if (secOk) begin
          load    = 1'b1;
          rdEn    = 1'b1;
          accAddr = addrIn;
        end else begin
          deselect = 1'b1;
        end
      end else if (ctrlStart) begin
        if (!selMain_n && secOk) begin
          load    = 1'b1;
          accAddr = addrIn;
          wrLane  = wrKeep;
          rdEn    = ~|wrReq;
        end else begin
          deselect = 1'b1;
        end
      end else if (activeQ) begin
        adv     = ~advance_n;
        accAddr = adv ? nextAddr : curAddr;
        wrLane  = wrKeep;
        rdEn    = ~|wrReq;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        activeQ <= 1'b0;
    else if (enterNow) activeQ <= 1'b0;
    else if (load)     activeQ <= 1'b1;
    else if (deselect) activeQ <= 1'b0;
  end

  assign cmd.rdEn   = rdEn;
  assign cmd.wrLane = wrLane;
  assign cmd.flush  = enterNow;

  // R3
  proc_start_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !procStrobe_n && !selMain_n) |-> (cmd.wrLane == '0));
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  memCmd_t           cmd,
  input  logic [AW-1:0]     accAddr,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              outEn_n,
  input  logic              sleep,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataDrive
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] wrBits;
  logic [AW-1:0]     rdAddrQ;
  logic              rdValidQ;
  logic [WORD_W-1:0] outQ;
  logic              drvQ;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    assign wrBits[l*LANE_W +: LANE_W] = {LANE_W{cmd.wrLane[l]}};
  end

  always_ff @(posedge clk) begin
    if (|cmd.wrLane) mem[accAddr] <= (mem[accAddr] & ~wrBits) | (dataIn & wrBits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdValidQ <= 1'b0;
      rdAddrQ  <= '0;
      outQ     <= '0;
      drvQ     <= 1'b0;
    end else begin
      rdValidQ <= cmd.rdEn & ~cmd.flush;
      rdAddrQ  <= accAddr;
      if (rdValidQ) outQ <= mem[rdAddrQ];
      drvQ     <= rdValidQ & ~(|cmd.wrLane) & ~cmd.flush;
    end
  end

  assign dataOut   = outQ;
  assign dataDrive = drvQ & ~outEn_n & ~sleep;

  // R6
  wr_drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd.wrLane) |=> !dataDrive);
endmodule

// File: rtl/sram_pipe_top.sv
module sram_pipe_top
  import sram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int ENTER_CYC = 2,
  parameter int WAKE_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              selMain_n,
  input  logic              selHi,
  input  logic              selLo_n,
  input  logic              procStrobe_n,
  input  logic              ctrlStrobe_n,
  input  logic              advance_n,
  input  logic              allWrite_n,
  input  logic              byteWrite_n,
  input  logic [1:0]        laneWrite_n,
  input  logic              outEn_n,
  input  logic              linearOrder,
  input  logic              snoozeReq,
  input  logic [17:0]       dataIn,
  output logic [17:0]       dataOut,
  output logic              dataDrive
);
  memCmd_t           cmd;
  logic [ADDR_W-1:0] accAddr;
  logic              sleep;
  logic              deselect;

  sram_ctrl #(.AW(ADDR_W), .ENTER_CYC(ENTER_CYC), .WAKE_CYC(WAKE_CYC)) uCtrl (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn),
    .selMain_n(selMain_n), .selHi(selHi), .selLo_n(selLo_n),
    .procStrobe_n(procStrobe_n), .ctrlStrobe_n(ctrlStrobe_n),
    .advance_n(advance_n), .allWrite_n(allWrite_n), .byteWrite_n(byteWrite_n),
    .laneWrite_n(laneWrite_n), .linearOrder(linearOrder), .snoozeReq(snoozeReq),
    .cmd(cmd), .accAddr(accAddr), .sleep(sleep), .deselect(deselect)
  );

  sram_datapath #(.AW(ADDR_W)) uData (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .accAddr(accAddr), .dataIn(dataIn),
    .outEn_n(outEn_n), .sleep(sleep), .dataOut(dataOut), .dataDrive(dataDrive)
  );

  // R7
  deselect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deselect |=> ##1 !dataDrive);
endmodule

// File: tb/sim_sram_pipe_top.sv
module sim_sram_pipe_top;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addrIn;
  logic        selMain_n, selHi, selLo_n, procStrobe_n, ctrlStrobe_n, advance_n;
  logic        allWrite_n, byteWrite_n, outEn_n, linearOrder, snoozeReq;
  logic [1:0]  laneWrite_n;
  logic [17:0] dataIn, dataOut;
  logic        dataDrive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [17:0] model [64];

  always #(CLK_NS/2) clk = ~clk;

  sram_pipe_top u0 (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn), .selMain_n(selMain_n), .selHi(selHi),
    .selLo_n(selLo_n), .procStrobe_n(procStrobe_n), .ctrlStrobe_n(ctrlStrobe_n),
    .advance_n(advance_n), .allWrite_n(allWrite_n), .byteWrite_n(byteWrite_n),
    .laneWrite_n(laneWrite_n), .outEn_n(outEn_n), .linearOrder(linearOrder),
    .snoozeReq(snoozeReq), .dataIn(dataIn), .dataOut(dataOut), .dataDrive(dataDrive)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    selMain_n = 0; selHi = 1; selLo_n = 0;
    procStrobe_n = 1; ctrlStrobe_n = 1; advance_n = 1;
    allWrite_n = 1; byteWrite_n = 1; laneWrite_n = 2'b11;
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic deselectNow();
    ctrlStrobe_n = 0; selMain_n = 1;
    step();
    idle();
    step();
  endtask

  task automatic readChk(int a, string tag);
    procStrobe_n = 0; addrIn = 6'(a);
    step();
    idle();
    step();
    chk(dataDrive == 1'b1, tag, {31'd0, dataDrive}, 1);
    chk(dataOut == model[a], tag, dataOut, model[a]);
    deselectNow();
  endtask

  task automatic writeAll(int a, logic [17:0] d);
    ctrlStrobe_n = 0; addrIn = 6'(a); allWrite_n = 0; laneWrite_n = 2'b11; dataIn = d;
    step();
    idle();
    model[a] = d;
  endtask

  task automatic writeLanes(int a, logic [17:0] d, logic [1:0] lanesN);
    ctrlStrobe_n = 0; addrIn = 6'(a); byteWrite_n = 0; laneWrite_n = lanesN; dataIn = d;
    step();
    idle();
    if (!lanesN[0]) model[a][8:0]  = d[8:0];
    if (!lanesN[1]) model[a][17:9] = d[17:9];
  endtask

  // R1: whole-word write ignores lane inputs
  task automatic tFullWrite();
    ctrlStrobe_n = 0; addrIn = 6'd5; allWrite_n = 0; byteWrite_n = 1;
    laneWrite_n = 2'b11; dataIn = 18'h2A5A5;
    step();
    idle();
    model[5] = 18'h2A5A5;
    readChk(5, "R1 full word");
  endtask

  // R2: per-lane writes and the no-lane read case
  task automatic tLaneWrite();
    writeAll(6, 18'h3FFFF);
    writeLanes(6, 18'h00000, 2'b10);
    readChk(6, "R2 lane a");
    writeLanes(6, 18'h15555, 2'b01);
    readChk(6, "R2 lane b");
    ctrlStrobe_n = 0; addrIn = 6'd6; byteWrite_n = 0; laneWrite_n = 2'b11; dataIn = 18'h0;
    step();
    idle();
    step();
    chk(dataDrive && dataOut == model[6], "R2 no lane is read", dataOut, model[6]);
    deselectNow();
  endtask

  // R3: processor start ignores write inputs
  task automatic tProcIgnoresWrite();
    writeAll(7, 18'h12345);
    procStrobe_n = 0; addrIn = 6'd7; allWrite_n = 0; dataIn = 18'h00000;
    step();
    idle();
    step();
    chk(dataDrive && dataOut == model[7], "R3 start is read", dataOut, model[7]);
    deselectNow();
    readChk(7, "R3 array unchanged");
  endtask

  // R4: one edge of pipeline latency
  task automatic tLatency();
    procStrobe_n = 0; addrIn = 6'd5;
    step();
    chk(dataDrive == 1'b0, "R4 not yet after first edge", {31'd0, dataDrive}, 0);
    idle();
    step();
    chk(dataDrive && dataOut == model[5], "R4 data after second edge", dataOut, model[5]);
    deselectNow();
  endtask

  task automatic burstRun(int start, bit lin, int e0, int e1, int e2, int e3, string tag);
    int exp [4];
    exp[0] = e0; exp[1] = e1; exp[2] = e2; exp[3] = e3;
    linearOrder = lin;
    procStrobe_n = 0; addrIn = 6'(start);
    step();
    idle();
    for (int i = 0; i < 4; i++) begin
      advance_n = (i < 3) ? 1'b0 : 1'b1;
      step();
      chk(dataOut == model[exp[i]], tag, dataOut, model[exp[i]]);
    end
    advance_n = 1;
    step();
    chk(dataOut == model[exp[3]], "R5 suspend holds beat", dataOut, model[exp[3]]);
    deselectNow();
    linearOrder = 1;
  endtask

  // R5: linear and interleaved beat orders
  task automatic tBurst();
    for (int a = 8; a < 12; a++) writeAll(a, 18'(32'h100 * a + a));
    burstRun(10, 1'b1, 10, 11, 8, 9, "R5 linear");
    burstRun(9, 1'b0, 9, 8, 11, 10, "R5 interleaved");
  endtask

  // R6: output enable gating and write forcing drive off
  task automatic tOutputEnable();
    procStrobe_n = 0; addrIn = 6'd5;
    step();
    idle();
    step();
    outEn_n = 1; #1;
    chk(dataDrive == 1'b0, "R6 outEn high", {31'd0, dataDrive}, 0);
    outEn_n = 0; #1;
    chk(dataDrive == 1'b1, "R6 outEn low", {31'd0, dataDrive}, 1);
    allWrite_n = 0; dataIn = 18'h0F0F0;
    step();
    model[5] = 18'h0F0F0;
    chk(dataDrive == 1'b0, "R6 write drops drive", {31'd0, dataDrive}, 0);
    idle();
    deselectNow();
    readChk(5, "R6 continue write landed");
  endtask

  // R7: deselect is two edges to drive off; R11 blocked processor strobe
  task automatic tDeselect();
    procStrobe_n = 0; addrIn = 6'd5;
    step();
    idle();
    step();
    ctrlStrobe_n = 0; selMain_n = 1;
    step();
    chk(dataDrive == 1'b1, "R7 drive holds one edge", {31'd0, dataDrive}, 1);
    idle();
    step();
    chk(dataDrive == 1'b0, "R7 drive off second edge", {31'd0, dataDrive}, 0);
    procStrobe_n = 0; addrIn = 6'd5;
    step();
    idle();
    step();
    procStrobe_n = 0; selHi = 0;
    step();
    idle();
    step();
    chk(dataDrive == 1'b0, "R7 secondary select deselect", {31'd0, dataDrive}, 0);
    writeAll(20, 18'h2AAAA);
    writeAll(21, 18'h15555);
    procStrobe_n = 0; addrIn = 6'd20;
    step();
    idle();
    step();
    procStrobe_n = 0; selMain_n = 1; addrIn = 6'd21;
    step();
    idle();
    step();
    chk(dataDrive && dataOut == model[20], "R11 blocked strobe", dataOut, model[20]);
    deselectNow();
  endtask

  // R8 / R9: snooze entry, retention, recovery window
  task automatic tSnooze();
    writeAll(30, 18'h03030);
    writeAll(31, 18'h13131);
    deselectNow();
    procStrobe_n = 0; addrIn = 6'd5;
    step();
    idle();
    step();
    snoozeReq = 1;
    step();
    chk(dataDrive == 1'b1, "R8 still awake after one edge", {31'd0, dataDrive}, 1);
    step();
    chk(dataDrive == 1'b0, "R8 asleep after two edges", {31'd0, dataDrive}, 0);
    ctrlStrobe_n = 0; addrIn = 6'd30; allWrite_n = 0; dataIn = 18'h3FFFF;
    step();
    step();
    snoozeReq = 0; addrIn = 6'd31; dataIn = 18'h00001;
    step();
    step();
    idle();
    readChk(31, "R9 recovery write ignored");
    readChk(30, "R8 retained");
    readChk(5, "R8 retained other");
  endtask

  // R10: write with snooze request pending is dropped
  task automatic tSnoozeDrop();
    writeAll(40, 18'h04040);
    writeAll(41, 18'h14141);
    deselectNow();
    ctrlStrobe_n = 0; addrIn = 6'd40; allWrite_n = 0; dataIn = 18'h2BEEF; snoozeReq = 1;
    step();
    idle();
    step();
    snoozeReq = 0;
    step();
    step();
    readChk(40, "R10 dropped write");
    readChk(41, "R10 neighbour intact");
  endtask

  initial begin
    rst_n = 0; addrIn = '0; dataIn = '0; outEn_n = 0; linearOrder = 1; snoozeReq = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk(dataDrive == 1'b0, "R6 reset drive low", {31'd0, dataDrive}, 0);
    tFullWrite();
    tLaneWrite();
    tProcIgnoresWrite();
    tLatency();
    tBurst();
    tOutputEnable();
    tDeselect();
    tSnooze();
    tSnoozeDrop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule